// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block places a 32x32 pixel cursor over a video pixel stream. Software programs the cursor through a small word-addressed register window. One word holds the position. Two banks of 32 row words hold the shape: a mask bank that marks the opaque pixels, and a colour-bit bank that chooses one of two cursor colours for each opaque pixel. A last word is a general-purpose status register.

On the pixel side, the block takes the raster coordinate of the current pixel, the colour of the pixel underneath and the two cursor colours. One clock later it returns either the underlying colour or a cursor colour. The frame fetch, the timing generator and the palette sit outside the block.

Each position or shape write also produces a one-cycle strobe. The strobe gives the span of screen rows that a display refresh engine must redraw. This span covers the rows under the old cursor and the rows under the new cursor, clipped to the screen. The screen width and height are parameters.

Top module: `hwcur_overlay`

## Requirements
- R1: A write to byte offset 0x8FC sets the cursor column from write bits 31:16 and the cursor row from write bits 15:0.
- R2: Shape row n (n = 0..31) is written at byte offset 0x900 + 4n for the mask bank and at 0x980 + 4n for the colour-bit bank.
- R3: Within a shape row word, bit 31 is the leftmost cursor column, and column c of the cursor uses bit 31 - c.
- R4: Where the mask bit is 1, the output is colour B if the colour bit is 1 and colour A if it is 0. Where the mask bit is 0, the underlying pixel is output unchanged.
- R5: The cursor covers raster rows y with cursor_y <= y < cursor_y + 32. The sum is formed without wrap, so a cursor row near 0xFFFF covers no low rows.
- R6: The cursor is drawn only when cursor_x < screen width. It covers columns x with cursor_x <= x < cursor_x + 32, and only those with x < screen width.
- R7: After reset both cursor coordinates are 0xF000 and all shape rows are zero, so every pixel passes through unchanged.
- R8: Register reads are combinational. Offset 0x818 returns the last value written there with bit 25 forced to 1, and it reads 0x02000000 after reset. Every other offset reads as zero.
- R9: One cycle after a position or shape write, dirty_valid is high for one cycle. The span runs from the lowest on-screen old or new cursor row to that row group's top plus 31, clipped to screen height - 1. There is no strobe when neither the old nor the new cursor row is on screen, and none for a write to 0x818.
- R10: The overlay output is registered, so the result for the inputs presented at one clock edge appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pix_x | input | 16 | Raster column of the current pixel |
| pix_y | input | 16 | Raster row of the current pixel |
| pix_in | input | PIXW | Underlying pixel colour |
| col_a | input | PIXW | Cursor colour for opaque pixels with colour bit 0 |
| col_b | input | PIXW | Cursor colour for opaque pixels with colour bit 1 |
| pix_out | output | PIXW | Composited pixel, one cycle later |
| dirty_valid | output | 1 | One-cycle strobe: the row span must be redrawn |
| dirty_first | output | 16 | First row of the span |
| dirty_last | output | 16 | Last row of the span |

## Verification
The hardest cases to reach are the clipping corners. In one the cursor straddles the right screen edge. In another it sits exactly on the last column or one past it. In a third its row lies so close to 0xFFFF that a wrapped sum would wrongly cover the top rows. The bench uses a small screen (40x48). It moves the cursor through each of these placements and sweeps every raster coordinate, including a few columns past the right edge. A model in the bench, built from the requirements, supplies the expected colour of each pixel. The sequence of moves also drives the dirty span through every case: old row off screen, new row off screen, both on screen, both off screen, and clipping at the bottom.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int CUR_N   = 32;
  localparam int ROW_AW  = $clog2(CUR_N);
  localparam int REG_AW  = 12;
  localparam logic [REG_AW-1:0] OFS_MISC = 12'h818;
  localparam logic [REG_AW-1:0] OFS_POS  = 12'h8FC;
  localparam logic [REG_AW-1:0] OFS_MASK = 12'h900;
  localparam logic [REG_AW-1:0] OFS_BITS = 12'h980;
  localparam logic [31:0] MISC_FORCE = 32'h0200_0000;
  localparam logic [15:0] POS_RESET  = 16'hF000;

  typedef enum logic [1:0] {SEL_PASS, SEL_A, SEL_B} pix_sel_e;
endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
  import hwcur_pkg::*;
#(
  parameter int SCR_H = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [15:0]       cur_x,
  output logic [15:0]       cur_y,
  output logic [31:0]       mask_q [CUR_N],
  output logic [31:0]       bits_q [CUR_N],
  output logic              dirty_valid,
  output logic [15:0]       dirty_first,
  output logic [15:0]       dirty_last
);
  localparam logic [16:0] H_L   = 17'(SCR_H);
  localparam logic [16:0] SPAN  = 17'(CUR_N - 1);
  localparam int          BANKB = ROW_AW + 2;

  logic hit_pos, hit_misc, hit_mask, hit_bits;
  logic [ROW_AW-1:0] row_sel;
  logic [15:0] x_q, y_q, y_nxt;
  logic [31:0] misc_q;
  logic [16:0] oy, ny, lo, top, hi, last_c;
  logic vis_o, vis_n, dirty_set;
  logic dv_q;
  logic [15:0] df_q, dl_q;

  // decode
  always_comb begin
    hit_pos  = we && (addr[REG_AW-1:2] == OFS_POS[REG_AW-1:2]);
    hit_misc = we && (addr[REG_AW-1:2] == OFS_MISC[REG_AW-1:2]);
    hit_mask = we && (addr[REG_AW-1:BANKB] == OFS_MASK[REG_AW-1:BANKB]);
    hit_bits = we && (addr[REG_AW-1:BANKB] == OFS_BITS[REG_AW-1:BANKB]);
    row_sel  = addr[BANKB-1:2];
    y_nxt    = hit_pos ? wdata[15:0] : y_q;
  end

  // read path
  always_comb begin
    if (addr[REG_AW-1:2] == OFS_MISC[REG_AW-1:2]) rdata = misc_q | MISC_FORCE;
    else                                          rdata = '0;
  end

  // redraw span of old and new cursor rows
  always_comb begin
    oy    = {1'b0, y_q};
    ny    = {1'b0, y_nxt};
    vis_o = oy < H_L;
    vis_n = ny < H_L;
    if (vis_o && vis_n) begin
      lo  = (oy < ny) ? oy : ny;
      top = (oy < ny) ? ny : oy;
    end else if (vis_o) begin
      lo  = oy;
      top = oy;
    end else begin
      lo  = ny;
      top = ny;
    end
    hi        = top + SPAN;
    last_c    = (hi > H_L - 17'd1) ? (H_L - 17'd1) : hi;
    dirty_set = (hit_pos || hit_mask || hit_bits) && (vis_o || vis_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= POS_RESET;
      y_q <= POS_RESET;
    end else if (hit_pos) begin
      x_q <= wdata[31:16];
      y_q <= wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        misc_q <= '0;
    else if (hit_misc) misc_q <= wdata;
  end

  for (genvar r = 0; r < CUR_N; r++) begin : g_row
    logic mwe, bwe;
    assign mwe = hit_mask && (row_sel == ROW_AW'(r));
    assign bwe = hit_bits && (row_sel == ROW_AW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q[r] <= '0;
      else if (mwe) mask_q[r] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bits_q[r] <= '0;
      else if (bwe) bits_q[r] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dv_q <= 1'b0;
    else        dv_q <= dirty_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df_q <= '0;
      dl_q <= '0;
    end else if (dirty_set) begin
      df_q <= lo[15:0];
      dl_q <= last_c[15:0];
    end
  end

  assign cur_x       = x_q;
  assign cur_y       = y_q;
  assign dirty_valid = dv_q;
  assign dirty_first = df_q;
  assign dirty_last  = dl_q;
endmodule

// File: rtl/hwcur_pixel.sv
module hwcur_pixel
  import hwcur_pkg::*;
#(
  parameter int SCR_W = 1024,
  parameter int PIXW  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     pix_x,
  input  logic [15:0]     pix_y,
  input  logic [PIXW-1:0] pix_in,
  input  logic [PIXW-1:0] col_a,
  input  logic [PIXW-1:0] col_b,
  input  logic [15:0]     cur_x,
  input  logic [15:0]     cur_y,
  input  logic [31:0]     mask_q [CUR_N],
  input  logic [31:0]     bits_q [CUR_N],
  output logic [PIXW-1:0] pix_out
);
  localparam logic [16:0] W_L  = 17'(SCR_W);
  localparam logic [16:0] N_L  = 17'(CUR_N);

  logic [16:0] dx, dy;
  logic in_x, in_y;
  logic [ROW_AW-1:0] col, row;
  logic m_bit, c_bit;
  pix_sel_e sel;
  logic [PIXW-1:0] out_d, out_q;

  always_comb begin
    dx    = {1'b0, pix_x} - {1'b0, cur_x};
    dy    = {1'b0, pix_y} - {1'b0, cur_y};
    in_y  = (pix_y >= cur_y) && (dy < N_L);
    in_x  = ({1'b0, cur_x} < W_L) && ({1'b0, pix_x} < W_L)
            && (pix_x >= cur_x) && (dx < N_L);
    col   = dx[ROW_AW-1:0];
    row   = dy[ROW_AW-1:0];
    // leftmost column maps to the top bit
    m_bit = mask_q[row][~col];
    c_bit = bits_q[row][~col];
    if (in_x && in_y && m_bit) sel = c_bit ? SEL_B : SEL_A;
    else                       sel = SEL_PASS;
    case (sel)
      SEL_A:   out_d = col_a;
      SEL_B:   out_d = col_b;
      default: out_d = pix_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pix_out = out_q;
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int SCR_W = 1024,
  parameter int SCR_H = 768,
  parameter int PIXW  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [15:0]       pix_x,
  input  logic [15:0]       pix_y,
  input  logic [PIXW-1:0]   pix_in,
  input  logic [PIXW-1:0]   col_a,
  input  logic [PIXW-1:0]   col_b,
  output logic [PIXW-1:0]   pix_out,
  output logic              dirty_valid,
  output logic [15:0]       dirty_first,
  output logic [15:0]       dirty_last
);
  logic [15:0] cur_x, cur_y;
  logic [31:0] mask_q [CUR_N];
  logic [31:0] bits_q [CUR_N];

  hwcur_regs #(.SCR_H(SCR_H)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .mask_q     (mask_q),
    .bits_q     (bits_q),
    .dirty_valid(dirty_valid),
    .dirty_first(dirty_first),
    .dirty_last (dirty_last)
  );

  hwcur_pixel #(.SCR_W(SCR_W), .PIXW(PIXW)) u_pixel (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_x  (pix_x),
    .pix_y  (pix_y),
    .pix_in (pix_in),
    .col_a  (col_a),
    .col_b  (col_b),
    .cur_x  (cur_x),
    .cur_y  (cur_y),
    .mask_q (mask_q),
    .bits_q (bits_q),
    .pix_out(pix_out)
  );
endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk
  import hwcur_pkg::*;
#(
  parameter int SCR_H = 768,
  parameter int PIXW  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [PIXW-1:0]   pix_in,
  input logic [PIXW-1:0]   col_a,
  input logic [PIXW-1:0]   col_b,
  input logic [PIXW-1:0]   pix_out,
  input logic              dirty_valid,
  input logic [15:0]       dirty_first,
  input logic [15:0]       dirty_last
);
  logic seen_q, moved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) moved_q <= 1'b0;
    else if (reg_we && reg_addr[REG_AW-1:2] == OFS_POS[REG_AW-1:2]) moved_q <= 1'b1;
  end

  assert_dirty_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> (dirty_first <= dirty_last) && (32'(dirty_last) < SCR_H));

  assert_dirty_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && dirty_valid) |-> $past(reg_we));

  assert_misc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[REG_AW-1:2] == OFS_MISC[REG_AW-1:2]) |-> reg_rdata[25]);

  assert_other_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[REG_AW-1:2] != OFS_MISC[REG_AW-1:2]) |-> (reg_rdata == '0));

  assert_reset_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !moved_q) |-> (pix_out == $past(pix_in)));

  assert_one_of_three_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (pix_out == $past(pix_in) || pix_out == $past(col_a)
                || pix_out == $past(col_b)));
endmodule

bind hwcur_overlay hwcur_overlay_chk #(.SCR_H(SCR_H), .PIXW(PIXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .pix_in     (pix_in),
  .col_a      (col_a),
  .col_b      (col_b),
  .pix_out    (pix_out),
  .dirty_valid(dirty_valid),
  .dirty_first(dirty_first),
  .dirty_last (dirty_last)
);

// File: tb/hwcur_overlay_bench.sv
`timescale 1ns/1ps
module hwcur_overlay_bench;
  localparam int W = 40;
  localparam int H = 48;
  localparam int PW = 24;
  localparam logic [PW-1:0] CA = 24'hAA0000;
  localparam logic [PW-1:0] CB = 24'h00BB00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [PW-1:0] pix_in = '0, col_a = CA, col_b = CB;
  logic [PW-1:0] pix_out;
  logic dirty_valid;
  logic [15:0] dirty_first, dirty_last;

  int checks = 0;
  int failures = 0;
  logic [31:0] bm_mask [32];
  logic [31:0] bm_bits [32];
  int bcx, bcy;

  always #2 clk = ~clk;

  hwcur_overlay #(.SCR_W(W), .SCR_H(H), .PIXW(PW)) u_hwcur_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .col_a(col_a), .col_b(col_b), .pix_out(pix_out),
    .dirty_valid(dirty_valid), .dirty_first(dirty_first), .dirty_last(dirty_last));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 12'h000;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // called right after wr(): the strobe is visible in this cycle
  task automatic dirty_chk(input bit v, input int f, input int l, input string req);
    chk(dirty_valid == v, req, 32'(dirty_valid), 32'(v));
    if (v) begin
      chk(dirty_first == 16'(f), req, 32'(dirty_first), 32'(f));
      chk(dirty_last == 16'(l), req, 32'(dirty_last), 32'(l));
    end
  endtask

  function automatic logic [PW-1:0] pix_of(input int x, input int y);
    return {8'(x), 8'(y), 8'h5A};
  endfunction

  function automatic logic [PW-1:0] expect_pix(input int x, input int y);
    int r, c;
    if (bcx < W && x < W && x >= bcx && x < bcx + 32 && y >= bcy && y < bcy + 32) begin
      r = y - bcy;
      c = x - bcx;
      if (bm_mask[r][31-c]) return bm_bits[r][31-c] ? CB : CA;
    end
    return pix_of(x, y);
  endfunction

  task automatic place(input int x, input int y);
    wr(12'h8FC, {16'(x), 16'(y)});
    bcx = x;
    bcy = y;
  endtask

  task automatic sweep(input string tag);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W + 4; x++) begin
        logic [PW-1:0] e;
        @(negedge clk);
        pix_x = 16'(x); pix_y = 16'(y); pix_in = pix_of(x, y);
        e = expect_pix(x, y);
        @(posedge clk); #1;
        chk(pix_out == e, tag, 32'(pix_out), 32'(e));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      bm_mask[r] = 32'hF0F0_3C3C ^ (32'h1 << r) ^ {r[7:0], 24'h0};
      bm_bits[r] = 32'hCC33_9966 ^ (32'(r) * 32'h0101_0101);
    end
    bcx = 32'hF000;
    bcy = 32'hF000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 / R8: reset state
    rd_chk(12'h818, 32'h0200_0000, "R8 reset misc");
    chk(dirty_valid == 1'b0, "R7 reset strobe", 32'(dirty_valid), 32'd0);
    @(negedge clk);
    pix_x = 16'd0; pix_y = 16'd0; pix_in = 24'h123456;
    @(posedge clk); #1;
    chk(pix_out == 24'h123456, "R7 R10 reset pass", 32'(pix_out), 32'h123456);

    // R8: misc register and other offsets
    wr(12'h818, 32'h0000_00FF);
    dirty_chk(1'b0, 0, 0, "R9 misc no strobe");
    rd_chk(12'h818, 32'h0200_00FF, "R8 misc readback");
    rd_chk(12'h8FC, 32'h0, "R8 other offset");
    rd_chk(12'h900, 32'h0, "R8 mask offset reads zero");

    // R1 / R9: first position, old off screen
    place(3, 2);
    dirty_chk(1'b1, 2, 33, "R9 old off new on");
    // R2: shape rows
    for (int r = 0; r < 32; r++) begin
      wr(12'h900 + 12'(4 * r), bm_mask[r]);
      wr(12'h980 + 12'(4 * r), bm_bits[r]);
    end
    dirty_chk(1'b1, 2, 33, "R9 row write strobe");
    sweep("R1,R2,R3,R4,R5 interior");

    place(20, 30);
    dirty_chk(1'b1, 2, 47, "R9 both on clipped");
    sweep("R6 right clip");

    place(39, 0);
    dirty_chk(1'b1, 0, 47, "R9 move up");
    sweep("R6 last column");

    place(40, 5);
    dirty_chk(1'b1, 0, 36, "R9 both on");
    sweep("R6 x equals width");

    place(5, 32'hFFF0);
    dirty_chk(1'b1, 5, 36, "R9 new off screen");
    sweep("R5 no wrap");

    place(5, 32'hFFF0);
    dirty_chk(1'b0, 0, 0, "R9 both off screen");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule